// File: doc/BRIEF.md
# Modulator Driver Segment Sequencer

This block turns a serial bit stream into enable signals for the four drive heads of a carrier-injection ring modulator. The heads are labelled A, B, C and D, and each one has its own strength code. The block runs on a fast phase clock. Each bit period is split into `SLOTS` sub-bit slots. The head pattern in each slot depends on the current bit and the bit before it:

- A rising edge starts with a strong burst on A and B together, then only B is held.
- A falling edge starts with a reverse-bias burst on D, then C supplies a weak forward bias for the rest of the zero.
- Steady ones keep only B on.
- Steady zeros keep only C on.

A new bit is taken at each bit boundary. A half-rate strobe toggles at every boundary, so the bits line up with both edges of that strobe, which gives double data rate. The bit source is selectable. It is either a pin that is sampled at the boundary or an on-chip 32-bit pseudorandom generator for self-test. Both burst lengths are set in slots, and the strength code of each head is passed through only while that head is enabled.

Top module: `segdrv_top`

## Requirements
- R1: During and right after reset, `head_en`, `head_drive`, `ddr_clk`, `tx_bit` and `slot` are all zero.
- R2: In the cycle after a clock edge that samples `run` low, `head_en` is zero and `slot` is zero. The next bit taken after `run` rises is treated as following a zero.
- R3: While `run` is high, `slot` counts 0 to `SLOTS`-1 and wraps. A new bit appears on `tx_bit` as `slot` returns to 0, and `ddr_clk` toggles with every new bit.
- R4: `head_en` bit 0 is A, bit 1 is B, bit 2 is C and bit 3 is D. For a 1 that follows a 0, `head_en` is 4'b0011 while `slot` < `rise_len` and 4'b0010 afterwards. A `rise_len` of 0 acts as 1.
- R5: For a 1 that follows a 1, `head_en` is 4'b0010 in every slot.
- R6: For a 0 that follows a 1, `head_en` is 4'b1000 while `slot` < `fall_len` and 4'b0100 afterwards. A `fall_len` of 0 acts as 1.
- R7: For a 0 that follows a 0, `head_en` is 4'b0100 in every slot.
- R8: A or B is never enabled in the same cycle as C or D.
- R9: Lane i of `head_drive` (bits i*`STR_W` and up) equals lane i of `head_str` when `head_en[i]` is set, and zero otherwise.
- R10: With `src_prbs` high, each new bit is bit 31 of a 32-bit register. The register then shifts left and takes in bit31^bit21^bit1^bit0 (x^32+x^22+x^2+x+1). It advances only when a bit is taken.
- R11: `seed_load` loads `seed_val` into the generator, and that load takes precedence over an advance in the same cycle. A zero seed is replaced by 32'h1ACEB00C, which is also the value after reset.
- R12: With `src_prbs` low, each new bit is the value of `ext_bit` at the clock edge where `slot` wraps, or at the edge where the sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-bit phase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Sequencing enable |
| src_prbs | input | 1 | 1 selects the generator, 0 selects `ext_bit` |
| ext_bit | input | 1 | External serial data |
| seed_load | input | 1 | Load the generator seed |
| seed_val | input | 32 | Generator seed |
| rise_len | input | LEN_W | A+B burst length in slots |
| fall_len | input | LEN_W | D burst length in slots |
| head_str | input | 4*STR_W | Strength code per head, A in the lowest lane |
| head_en | output | 4 | Head enables {D,C,B,A} |
| head_drive | output | 4*STR_W | Gated strength code per head |
| ddr_clk | output | 1 | Bit strobe that toggles at every bit boundary |
| tx_bit | output | 1 | Bit currently being driven |
| slot | output | LEN_W | Current sub-bit slot |

## Verification
The assertions check every cycle that the A/B pair and the C/D pair are never on together. They also check that:
- a low-side head is always on alone,
- A never appears in the last slot,
- undriven lanes of `head_drive` stay at zero,
- the slot wraps correctly,
- the generator never holds zero,
- a cycle that samples `run` low leaves every head off.

Only the bench scenarios can show the rest. That covers:
- the exact burst lengths for each length code, including the clamping of code 0,
- the order of bits from the generator after zero and nonzero seeds,
- sampling of `ext_bit` at the boundary,
- the DDR strobe toggling in step with new bits.

// File: rtl/segdrv_pkg.sv
package segdrv_pkg;
  localparam int unsigned HEADS  = 4;
  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] SEED_FIX = 32'h1ACE_B00C;

  typedef enum logic [1:0] {
    HD_A = 2'd0,
    HD_B = 2'd1,
    HD_C = 2'd2,
    HD_D = 2'd3
  } head_idx_e;
endpackage

// File: rtl/segdrv_prbs.sv
module segdrv_prbs
  import segdrv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic              load,
  input  logic [LFSR_W-1:0] seed,
  output logic              bit_out
);
  logic [LFSR_W-1:0] state_q, state_d;
  logic              fb;
  logic              state_en;

  // Taps for x^32 + x^22 + x^2 + x + 1
  assign fb       = state_q[31] ^ state_q[21] ^ state_q[1] ^ state_q[0];
  assign state_en = load | advance;
  assign bit_out  = state_q[LFSR_W-1];

  always_comb begin
    if (load) begin
      state_d = (seed == '0) ? SEED_FIX : seed;
    end else begin
      state_d = {state_q[LFSR_W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_FIX;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  // R11: the generator can never lock up at zero
  assert_prbs_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/segdrv_timing.sv
module segdrv_timing #(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned LEN_W = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             new_bit,
  output logic             take_bit,
  output logic             active,
  output logic [LEN_W-1:0] slot,
  output logic             cur_bit,
  output logic             prev_bit,
  output logic             ddr_clk
);
  localparam logic [LEN_W-1:0] LAST = LEN_W'(SLOTS - 1);

  logic             active_q, active_d;
  logic [LEN_W-1:0] slot_q, slot_d;
  logic             cur_q, cur_d;
  logic             prev_q, prev_d;
  logic             ddr_q, ddr_d;

  assign take_bit = run & (~active_q | (slot_q == LAST));

  always_comb begin
    active_d = active_q;
    slot_d   = slot_q;
    cur_d    = cur_q;
    prev_d   = prev_q;
    ddr_d    = ddr_q;
    if (!run) begin
      active_d = 1'b0;
      slot_d   = '0;
    end else if (take_bit) begin
      active_d = 1'b1;
      slot_d   = '0;
      cur_d    = new_bit;
      prev_d   = active_q & cur_q;
      ddr_d    = ~ddr_q;
    end else begin
      slot_d   = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      cur_q    <= 1'b0;
      prev_q   <= 1'b0;
      ddr_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      slot_q   <= slot_d;
      cur_q    <= cur_d;
      prev_q   <= prev_d;
      ddr_q    <= ddr_d;
    end
  end

  assign active   = active_q;
  assign slot     = slot_q;
  assign cur_bit  = cur_q;
  assign prev_bit = prev_q;
  assign ddr_clk  = ddr_q;

  // R3: the last slot of a running bit is followed by slot zero
  assert_slot_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && active_q && slot_q == LAST) |=> (slot_q == '0));
endmodule

// File: rtl/segdrv_heads.sv
module segdrv_heads
  import segdrv_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned STR_W = 4,
  localparam int unsigned LEN_W = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   active,
  input  logic                   cur_bit,
  input  logic                   prev_bit,
  input  logic [LEN_W-1:0]       slot,
  input  logic [LEN_W-1:0]       rise_len,
  input  logic [LEN_W-1:0]       fall_len,
  input  logic [HEADS*STR_W-1:0] str_in,
  output logic [HEADS-1:0]       en,
  output logic [HEADS*STR_W-1:0] drive
);
  localparam logic [LEN_W-1:0] ONE  = LEN_W'(1);
  localparam logic [LEN_W-1:0] LAST = LEN_W'(SLOTS - 1);

  logic [LEN_W-1:0] rise_eff, fall_eff;

  assign rise_eff = (rise_len == '0) ? ONE : rise_len;
  assign fall_eff = (fall_len == '0) ? ONE : fall_len;

  always_comb begin
    en = '0;
    if (active) begin
      unique case ({prev_bit, cur_bit})
        2'b01: begin
          en[HD_B] = 1'b1;
          en[HD_A] = (slot < rise_eff);
        end
        2'b11: en[HD_B] = 1'b1;
        2'b10: begin
          if (slot < fall_eff) en[HD_D] = 1'b1;
          else                 en[HD_C] = 1'b1;
        end
        default: en[HD_C] = 1'b1;
      endcase
    end
  end

  for (genvar h = 0; h < HEADS; h++) begin : g_lane
    assign drive[h*STR_W +: STR_W] = en[h] ? str_in[h*STR_W +: STR_W] : '0;

    // R9: a disabled head's lane carries no strength
    assert_lane_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en[h] |-> (drive[h*STR_W +: STR_W] == '0));
  end

  // R8: high side and low side never overlap
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((en[HD_A] | en[HD_B]) & (en[HD_C] | en[HD_D])));

  // R6, R7: a low-side head is always the only enabled head
  assert_low_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en[HD_C] | en[HD_D]) |-> ($countones(en) == 1));

  // R4: the A+B burst never reaches the final slot
  assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en[HD_A] |-> (slot != LAST));
endmodule

// File: rtl/segdrv_top.sv
module segdrv_top
  import segdrv_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  parameter int unsigned STR_W = 4,
  localparam int unsigned LEN_W = (SLOTS > 2) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic                   src_prbs,
  input  logic                   ext_bit,
  input  logic                   seed_load,
  input  logic [31:0]            seed_val,
  input  logic [LEN_W-1:0]       rise_len,
  input  logic [LEN_W-1:0]       fall_len,
  input  logic [4*STR_W-1:0]     head_str,
  output logic [3:0]             head_en,
  output logic [4*STR_W-1:0]     head_drive,
  output logic                   ddr_clk,
  output logic                   tx_bit,
  output logic [LEN_W-1:0]       slot
);
  logic prbs_bit, take_bit, active, cur_bit, prev_bit, sel_bit;

  assign sel_bit = src_prbs ? prbs_bit : ext_bit;

  segdrv_prbs u_prbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (take_bit & src_prbs),
    .load    (seed_load),
    .seed    (seed_val),
    .bit_out (prbs_bit)
  );

  segdrv_timing #(.SLOTS(SLOTS)) u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .new_bit  (sel_bit),
    .take_bit (take_bit),
    .active   (active),
    .slot     (slot),
    .cur_bit  (cur_bit),
    .prev_bit (prev_bit),
    .ddr_clk  (ddr_clk)
  );

  segdrv_heads #(.SLOTS(SLOTS), .STR_W(STR_W)) u_heads (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .cur_bit  (cur_bit),
    .prev_bit (prev_bit),
    .slot     (slot),
    .rise_len (rise_len),
    .fall_len (fall_len),
    .str_in   (head_str),
    .en       (head_en),
    .drive    (head_drive)
  );

  assign tx_bit = cur_bit;

  // R2: a cycle that samples run low leaves every head off
  assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (head_en == 4'b0000));
endmodule

// File: tb/segdrv_top_tb_top.sv
module segdrv_top_tb_top;
  localparam int SLOTS = 4;
  localparam int STR_W = 4;
  localparam int LEN_W = 2;
  localparam logic [31:0] FIXSEED = 32'h1ACE_B00C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, src_prbs = 1'b0, ext_bit = 1'b0, seed_load = 1'b0;
  logic [31:0] seed_val = '0;
  logic [LEN_W-1:0] rise_len = 2'd1, fall_len = 2'd1;
  logic [4*STR_W-1:0] head_str = 16'h4321;
  logic [3:0] head_en;
  logic [4*STR_W-1:0] head_drive;
  logic ddr_clk, tx_bit;
  logic [LEN_W-1:0] slot;

  int n_chk = 0, n_bad = 0;
  bit zero_seed_phase = 1'b0;

  segdrv_top #(.SLOTS(SLOTS), .STR_W(STR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .src_prbs(src_prbs), .ext_bit(ext_bit),
    .seed_load(seed_load), .seed_val(seed_val), .rise_len(rise_len),
    .fall_len(fall_len), .head_str(head_str), .head_en(head_en),
    .head_drive(head_drive), .ddr_clk(ddr_clk), .tx_bit(tx_bit), .slot(slot)
  );

  always #5 clk = ~clk;

  // Reference state, written from the requirements
  logic m_act, m_bit, m_prev, m_ddr;
  logic [1:0] m_slot;
  logic [31:0] m_lfsr;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [3:0] exp_en(input logic a, input logic b, input logic p,
                                        input logic [1:0] s, input logic [1:0] rl,
                                        input logic [1:0] fl);
    logic [1:0] r, f;
    r = (rl == 0) ? 2'd1 : rl;
    f = (fl == 0) ? 2'd1 : fl;
    if (!a) return 4'b0000;
    if (b && !p) return (s < r) ? 4'b0011 : 4'b0010;
    if (b && p) return 4'b0010;
    if (!b && p) return (s < f) ? 4'b1000 : 4'b0100;
    return 4'b0100;
  endfunction

  function automatic logic [15:0] exp_drive(input logic [3:0] e, input logic [15:0] st);
    logic [15:0] d;
    for (int h = 0; h < 4; h++) d[h*4 +: 4] = e[h] ? st[h*4 +: 4] : 4'h0;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 0; m_bit <= 0; m_prev <= 0; m_ddr <= 0; m_slot <= 0; m_lfsr <= FIXSEED;
    end else begin
      logic take;
      take = run && (!m_act || m_slot == 2'd3);
      if (seed_load) m_lfsr <= (seed_val == 0) ? FIXSEED : seed_val;
      else if (take && src_prbs) m_lfsr <= lfsr_step(m_lfsr);
      if (!run) begin
        m_act <= 0; m_slot <= 0;
      end else if (take) begin
        m_act <= 1; m_slot <= 0;
        m_bit <= src_prbs ? m_lfsr[31] : ext_bit;
        m_prev <= m_act & m_bit;
        m_ddr <= ~m_ddr;
      end else begin
        m_slot <= m_slot + 2'd1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [3:0] e;
    string tag, ttag;
    e = exp_en(m_act, m_bit, m_prev, m_slot, rise_len, fall_len);
    if (!m_act) tag = "R2";
    else if (m_bit && !m_prev) tag = "R4";
    else if (m_bit) tag = "R5";
    else if (m_prev) tag = "R6";
    else tag = "R7";
    check(tag, {28'd0, head_en}, {28'd0, e});
    check("R9", {16'd0, head_drive}, {16'd0, exp_drive(e, head_str)});
    check("R3", {29'd0, ddr_clk, slot}, {29'd0, m_ddr, m_slot});
    ttag = !src_prbs ? "R12" : (zero_seed_phase ? "R11" : "R10");
    check(ttag, {31'd0, tx_bit}, {31'd0, m_bit});
    check("R8", {31'd0, (|head_en[1:0]) & (|head_en[3:2])}, 32'd0);
  endtask

  initial begin
    #(10 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {16'd0, head_drive}, 32'd0);
    check("R1", {27'd0, head_en, ddr_clk}, 32'd0);
    check("R1", {29'd0, tx_bit, slot}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {26'd0, head_en, tx_bit, ddr_clk}, 32'd0);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      check_all();
      seed_load = 1'b0;
      ext_bit = 1'($urandom_range(0, 1));
      if (cyc < 200) begin
        run = 1; src_prbs = 0; rise_len = 2'd2; fall_len = 2'd1;
      end else if (cyc < 400) begin
        rise_len = 2'd0; fall_len = 2'd3;  // length code 0 acts as 1 (R4, R6)
      end else if (cyc < 600) begin
        rise_len = 2'd3; fall_len = 2'd0;
        run = ($urandom_range(0, 19) != 0);  // R2: random stops
      end else if (cyc == 600) begin
        run = 0; seed_load = 1; seed_val = 32'd0; src_prbs = 1; zero_seed_phase = 1;
      end else if (cyc < 1400) begin
        run = 1;
        if ($urandom_range(0, 15) == 0) begin
          rise_len = 2'($urandom_range(0, 3)); fall_len = 2'($urandom_range(0, 3));
        end
      end else if (cyc == 1400) begin
        run = 0; seed_load = 1; seed_val = $urandom | 32'h1; zero_seed_phase = 0;
      end else begin
        run = ($urandom_range(0, 40) != 0);
        head_str = 16'($urandom);
        if ($urandom_range(0, 7) == 0) begin
          rise_len = 2'($urandom_range(0, 3)); fall_len = 2'($urandom_range(0, 3));
        end
        if ($urandom_range(0, 500) == 0) src_prbs = ~src_prbs;
      end
      @(negedge clk);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule